// File: doc/BRIEF.md
# Stereo Serial Audio Capture Controller

This block receives a stereo serial audio stream for recording. It watches a bit clock, a word-select line and a serial data line. It turns each channel slot into one sample of the selected size and queues the sample, together with its channel tag, in a receive buffer that holds 32 samples. A consumer takes samples from the head of the buffer through a simple pop port. The head entry is always shown on the read outputs.

Status follows the buffer fill level. A threshold flag is high while the level is at or above a trigger value, which defaults to one quarter of the depth minus one (7 for 32 entries). A DMA request follows that flag when DMA is enabled. If a sample completes while the buffer is full, the sample is dropped and a sticky overrun flag is set. One interrupt line combines the two flags through an enable mask. A flush pulse empties the buffer. Software issues it before recording is switched on.

The serial inputs are expected to be already in the system clock domain and much slower than it. Each bit clock phase lasts at least two system clocks.

Top module: `i2s_rx_ctrl`

## Requirements
- R1: After reset the buffer is empty, the level is 0, and the threshold, DMA request, overrun and interrupt outputs are all low.
- R2: Data is sampled on rising bit clock edges, MSB first. The MSB is the bit sampled on the first rising edge after the edge at which a word-select change is seen. In 16-bit mode (size16=1) the 16 bits sampled from that edge onward form the sample.
- R3: In 8-bit mode (size16=0) the first 8 bits of the slot form the sample. It is right-justified in rd_data[7:0], with rd_data[15:8] zero, and the rest of the slot is ignored.
- R4: Each stored sample carries the word-select level of its slot on rd_ch (0 for left, 1 for right). Consecutive slots alternate.
- R5: Samples are read out in arrival order. fifo_level gives the number of stored samples, and the buffer holds up to 32.
- R6: thr_flag is high exactly while fifo_level >= TRIG, where TRIG defaults to 7.
- R7: dma_req is high exactly while thr_flag and dma_en are both high.
- R8: A sample that completes while the buffer holds 32 entries is discarded, and the stored contents are unchanged. ovr_flag is set and stays set until an ovr_clr pulse.
- R9: irq = (irq_mask[1] & thr_flag) | (irq_mask[3] & ovr_flag). Mask bits 0 and 2 have no effect.
- R10: A flush pulse empties the buffer (level 0, rd_empty high) and leaves ovr_flag unchanged.
- R11: While rec_en is low no sample is stored. After rec_en rises, capture starts only at the next word-select change.
- R12: A pop request while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_en | input | 1 | Recording enable |
| size16 | input | 1 | 1: 16-bit samples, 0: 8-bit samples |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word select (channel) |
| sd | input | 1 | Serial data |
| flush | input | 1 | One-cycle pulse that empties the buffer |
| dma_en | input | 1 | Enables the DMA request |
| irq_mask | input | 4 | Interrupt enables: bit 1 threshold, bit 3 overrun |
| ovr_clr | input | 1 | One-cycle pulse that clears the overrun flag |
| rd_en | input | 1 | Pop the head sample |
| rd_data | output | 16 | Head sample, right-justified |
| rd_ch | output | 1 | Channel tag of the head sample |
| rd_empty | output | 1 | Buffer empty |
| fifo_level | output | 6 | Number of stored samples |
| thr_flag | output | 1 | Level at or above the trigger |
| dma_req | output | 1 | DMA request |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume each bit clock phase lasts at least two system clocks, so a detected rising edge never repeats on back-to-back cycles. They also assume the serial lines change only while the bit clock is low. The bench drives every bit as two system clocks low followed by two high, and changes word select and data only at the start of the low phase. Flush, pop and size changes are applied only while the serial clock is idle, so an arriving sample never coincides with a flush or a pop.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
    localparam int RX_MAX_W = 16;

    typedef struct packed {
        logic                ch;
        logic [RX_MAX_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser #(
    parameter int MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             size16,
    input  logic             sck,
    input  logic             ws,
    input  logic             sd,
    output logic             word_vld,
    output logic [MAX_W-1:0] word_data,
    output logic             word_ch
);
    localparam int CW = $clog2(MAX_W) + 1;
    localparam logic [CW-1:0] FULL_BITS = CW'(MAX_W);
    localparam logic [CW-1:0] HALF_BITS = CW'(MAX_W / 2);

    typedef struct packed {
        logic             sck_s;
        logic             sck_p;
        logic             ws_s;
        logic             sd_s;
        logic             ws_prev;
        logic             start_pend;
        logic             active;
        logic [CW-1:0]    cnt;
        logic [MAX_W-1:0] shreg;
        logic             ch;
        logic             vld;
        logic [MAX_W-1:0] data;
        logic             ch_out;
    } deser_t;

    deser_t st_q, st_d;
    logic             rise;
    logic [CW-1:0]    need;
    logic [MAX_W-1:0] shifted;

    always_comb begin
        st_d       = st_q;
        st_d.sck_s = sck;
        st_d.ws_s  = ws;
        st_d.sd_s  = sd;
        st_d.sck_p = st_q.sck_s;
        st_d.vld   = 1'b0;
        rise       = st_q.sck_s & ~st_q.sck_p;
        need       = size16 ? FULL_BITS : HALF_BITS;
        shifted    = {st_q.shreg[MAX_W-2:0], st_q.sd_s};
        if (rise) begin
            st_d.ws_prev = st_q.ws_s;
            if (st_q.start_pend) begin
                st_d.shreg      = {{(MAX_W-1){1'b0}}, st_q.sd_s};
                st_d.cnt        = CW'(1);
                st_d.active     = 1'b1;
                st_d.ch         = st_q.ws_s;
                st_d.start_pend = 1'b0;
            end else if (st_q.active) begin
                st_d.shreg = shifted;
                st_d.cnt   = st_q.cnt + CW'(1);
                if (st_q.cnt + CW'(1) == need) begin
                    st_d.vld    = 1'b1;
                    st_d.data   = shifted;
                    st_d.ch_out = st_q.ch;
                    st_d.active = 1'b0;
                end
            end
            if (st_q.ws_s != st_q.ws_prev) begin
                st_d.start_pend = 1'b1;
            end
        end
        if (!en) begin
            st_d.start_pend = 1'b0;
            st_d.active     = 1'b0;
            st_d.vld        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld  = st_q.vld;
    assign word_data = st_q.data;
    assign word_ch   = st_q.ch_out;

    // R2
    single_word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R11
    no_word_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !word_vld);
endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 17
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       empty,
    output logic                       full,
    output logic                       overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr_ptr;
        logic [AW-1:0]           rd_ptr;
        logic [AW:0]             count;
    } fifo_t;

    fifo_t fq, fd;
    logic push_ok, pop_ok;

    always_comb begin
        fd      = fq;
        push_ok = push & ~full & ~flush;
        pop_ok  = pop & ~empty & ~flush;
        overrun = push & full & ~flush;
        if (flush) begin
            fd.wr_ptr = '0;
            fd.rd_ptr = '0;
            fd.count  = '0;
        end else begin
            if (push_ok) begin
                fd.mem[fq.wr_ptr] = push_data;
                fd.wr_ptr         = fq.wr_ptr + AW'(1);
            end
            if (pop_ok) begin
                fd.rd_ptr = fq.rd_ptr + AW'(1);
            end
            case ({push_ok, pop_ok})
                2'b10:   fd.count = fq.count + (AW+1)'(1);
                2'b01:   fd.count = fq.count - (AW+1)'(1);
                default: fd.count = fq.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq <= '0;
        end else begin
            fq <= fd;
        end
    end

    assign head  = fq.mem[fq.rd_ptr];
    assign level = fq.count;
    assign empty = (fq.count == '0);
    assign full  = (fq.count == DEPTH_L);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

    // R8
    full_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == DEPTH_L));

    // R12
    empty_pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (empty && $stable(fq.rd_ptr)));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L);
endmodule

// File: rtl/i2s_rx_status.sv
module i2s_rx_status #(
    parameter int LVL_W = 6,
    parameter int TRIG  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             overrun_evt,
    input  logic             ovr_clr,
    input  logic             dma_en,
    input  logic [3:0]       irq_mask,
    output logic             thr_flag,
    output logic             dma_req,
    output logic             ovr_flag,
    output logic             irq
);
    localparam logic [LVL_W-1:0] TRIG_L = LVL_W'(TRIG);

    typedef struct packed {
        logic ovr;
    } stat_t;

    stat_t sq, sd_n;

    always_comb begin
        sd_n = sq;
        if (ovr_clr) begin
            sd_n.ovr = 1'b0;
        end
        if (overrun_evt) begin
            sd_n.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq <= '0;
        end else begin
            sq <= sd_n;
        end
    end

    assign thr_flag = (level >= TRIG_L);
    assign dma_req  = thr_flag & dma_en;
    assign ovr_flag = sq.ovr;
    assign irq      = (irq_mask[1] & thr_flag) | (irq_mask[3] & sq.ovr);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_evt |=> ovr_flag);

    // R9
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_mask[1] && !irq_mask[3]) |-> !irq);
endmodule

// File: rtl/i2s_rx_ctrl.sv
module i2s_rx_ctrl
    import i2s_rx_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int TRIG  = DEPTH / 4 - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rec_en,
    input  logic                    size16,
    input  logic                    sck,
    input  logic                    ws,
    input  logic                    sd,
    input  logic                    flush,
    input  logic                    dma_en,
    input  logic [3:0]              irq_mask,
    input  logic                    ovr_clr,
    input  logic                    rd_en,
    output logic [RX_MAX_W-1:0]     rd_data,
    output logic                    rd_ch,
    output logic                    rd_empty,
    output logic [$clog2(DEPTH):0]  fifo_level,
    output logic                    thr_flag,
    output logic                    dma_req,
    output logic                    ovr_flag,
    output logic                    irq
);
    localparam int LVL_W = $clog2(DEPTH) + 1;
    localparam int EW    = $bits(rx_word_t);

    logic                word_vld;
    logic [RX_MAX_W-1:0] word_data;
    logic                word_ch;
    rx_word_t            wr_word, head_word;
    logic [EW-1:0]       head_bits;
    logic                full, overrun;

    i2s_rx_deser #(.MAX_W(RX_MAX_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rec_en),
        .size16    (size16),
        .sck       (sck),
        .ws        (ws),
        .sd        (sd),
        .word_vld  (word_vld),
        .word_data (word_data),
        .word_ch   (word_ch)
    );

    assign wr_word.ch   = word_ch;
    assign wr_word.data = word_data;

    i2s_rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (word_vld),
        .push_data (wr_word),
        .pop       (rd_en),
        .flush     (flush),
        .head      (head_bits),
        .level     (fifo_level),
        .empty     (rd_empty),
        .full      (full),
        .overrun   (overrun)
    );

    assign head_word = rx_word_t'(head_bits);
    assign rd_data   = head_word.data;
    assign rd_ch     = head_word.ch;

    i2s_rx_status #(.LVL_W(LVL_W), .TRIG(TRIG)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (fifo_level),
        .overrun_evt (overrun),
        .ovr_clr     (ovr_clr),
        .dma_en      (dma_en),
        .irq_mask    (irq_mask),
        .thr_flag    (thr_flag),
        .dma_req     (dma_req),
        .ovr_flag    (ovr_flag),
        .irq         (irq)
    );

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_empty);
endmodule

// File: tb/tb_i2s_rx_ctrl.sv
`timescale 1ns/1ps
module tb_i2s_rx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_en = 1'b0, size16 = 1'b1;
    logic        sck = 1'b1, ws = 1'b0, sd = 1'b0;
    logic        flush = 1'b0, dma_en = 1'b0, ovr_clr = 1'b0, rd_en = 1'b0;
    logic [3:0]  irq_mask = 4'b0000;
    logic [15:0] rd_data;
    logic        rd_ch, rd_empty, thr_flag, dma_req, ovr_flag, irq;
    logic [5:0]  fifo_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [16:0] mq[$];
    bit          m_ovr = 1'b0;
    logic        next_ws = 1'b0;
    logic        prev_lsb = 1'b0;
    bit          started = 1'b0;

    always #2.5 clk = ~clk;

    i2s_rx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .size16(size16),
        .sck(sck), .ws(ws), .sd(sd), .flush(flush), .dma_en(dma_en),
        .irq_mask(irq_mask), .ovr_clr(ovr_clr), .rd_en(rd_en),
        .rd_data(rd_data), .rd_ch(rd_ch), .rd_empty(rd_empty),
        .fifo_level(fifo_level), .thr_flag(thr_flag), .dma_req(dma_req),
        .ovr_flag(ovr_flag), .irq(irq)
    );

    function automatic logic [15:0] exp_sample(logic [15:0] d, logic s16);
        return s16 ? d : {8'h00, d[15:8]};
    endfunction

    function automatic logic exp_irq(logic [3:0] m, logic thr, logic ovr);
        return (m[1] & thr) | (m[3] & ovr);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_period(logic w, logic s);
        @(negedge clk);
        sck = 1'b0; ws = w; sd = s;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_slot(logic [15:0] d, bit expect_it);
        for (int b = 0; b < 16; b++) begin
            if (b == 0 && started) continue;
            bit_period(next_ws, (b == 0) ? prev_lsb : d[16-b]);
        end
        started  = 1'b0;
        prev_lsb = d[0];
        if (expect_it) begin
            if (mq.size() < 32) mq.push_back({next_ws, exp_sample(d, size16)});
            else m_ovr = 1'b1;
        end
        next_ws = ~next_ws;
    endtask

    task automatic close_burst();
        bit_period(next_ws, prev_lsb);
        started = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_rand(int n, bit expect_it);
        for (int i = 0; i < n; i++) send_slot(16'($urandom), expect_it);
        close_burst();
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_one(string tag);
        logic [16:0] e;
        @(negedge clk);
        e = mq.pop_front();
        chk({tag, " data"}, int'(rd_data), int'(e[15:0]));
        chk("R4 channel", int'(rd_ch), int'(e[16]));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(string tag);
        int n;
        n = mq.size();
        for (int i = 0; i < n; i++) read_one(tag);
        @(negedge clk);
        chk("R5 drained level", int'(fifo_level), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", int'(rd_empty), 1);
        chk("R1 level", int'(fifo_level), 0);
        chk("R1 thr", int'(thr_flag), 0);
        chk("R1 dma", int'(dma_req), 0);
        chk("R1 ovr", int'(ovr_flag), 0);
        chk("R1 irq", int'(irq), 0);

        // R10 flush before enable, then prime word-select
        pulse(flush);
        chk("R10 flush empty", int'(rd_empty), 1);
        rec_en = 1'b1;
        bit_period(1'b1, 1'b0);

        // R2 R4 directed 16-bit samples
        send_slot(16'h8001, 1'b1);
        send_slot(16'h7FFE, 1'b1);
        send_slot(16'hA5C3, 1'b1);
        send_slot(16'h0F0F, 1'b1);
        close_burst();
        chk("R5 level 4", int'(fifo_level), 4);
        chk("R6 thr below", int'(thr_flag), 0);
        drain("R2 sample16");

        // R6 threshold boundary
        send_rand(6, 1'b1);
        chk("R6 level 6 thr low", int'(thr_flag), 0);
        send_rand(1, 1'b1);
        chk("R6 level 7 thr high", int'(thr_flag), 1);
        // R7
        dma_en = 1'b0; @(negedge clk);
        chk("R7 dma off", int'(dma_req), 0);
        dma_en = 1'b1; @(negedge clk);
        chk("R7 dma on", int'(dma_req), 1);
        // R9
        irq_mask = 4'b0010; @(negedge clk);
        chk("R9 thr irq", int'(irq), int'(exp_irq(irq_mask, 1'b1, 1'b0)));
        irq_mask = 4'b0101; @(negedge clk);
        chk("R9 other bits", int'(irq), 0);
        irq_mask = 4'b1000; @(negedge clk);
        chk("R9 ovr masked in no ovr", int'(irq), 0);

        // R8 overrun
        send_rand(25, 1'b1);
        chk("R5 full level", int'(fifo_level), 32);
        chk("R8 no ovr yet", int'(ovr_flag), 0);
        send_rand(2, 1'b1);
        chk("R8 level kept", int'(fifo_level), 32);
        chk("R8 ovr set", int'(ovr_flag), int'(m_ovr));
        chk("R9 ovr irq", int'(irq), 1);
        drain("R8 contents kept");
        chk("R8 ovr sticky", int'(ovr_flag), 1);
        chk("R6 thr empty", int'(thr_flag), 0);

        // R10 flush keeps overrun
        send_rand(3, 1'b0);
        chk("R10 pre-flush level", int'(fifo_level), 3);
        pulse(flush);
        chk("R10 flushed level", int'(fifo_level), 0);
        chk("R10 ovr kept", int'(ovr_flag), 1);
        pulse(ovr_clr);
        m_ovr = 1'b0;
        chk("R8 ovr cleared", int'(ovr_flag), 0);

        // R12 pop while empty
        pulse(rd_en);
        chk("R12 level", int'(fifo_level), 0);
        send_rand(1, 1'b1);
        chk("R12 level after", int'(fifo_level), 1);
        drain("R12 data intact");

        // R3 8-bit mode
        size16 = 1'b0;
        send_slot(16'hC3FF, 1'b1);
        send_slot(16'h5A00, 1'b1);
        send_rand(4, 1'b1);
        drain("R3 sample8");
        size16 = 1'b1;

        // R11 disabled capture
        rec_en = 1'b0;
        send_rand(3, 1'b1 == 1'b0);
        chk("R11 nothing stored", int'(fifo_level), 0);
        rec_en = 1'b1;
        send_rand(1, 1'b0);
        chk("R11 no capture before ws change", int'(fifo_level), 0);
        send_rand(2, 1'b1);
        chk("R11 resumed", int'(fifo_level), 2);
        drain("R11 resumed data");

        // random phase
        for (int it = 0; it < 20; it++) begin
            int n;
            n = 1 + int'($urandom % 10);
            size16 = 1'($urandom);
            send_rand(n, 1'b1);
            chk("R6 random thr", int'(thr_flag), (mq.size() >= 7) ? 1 : 0);
            chk("R5 random level", int'(fifo_level), mq.size());
            drain(size16 ? "R2 random" : "R3 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule